// File: doc/BRIEF.md
# Host-to-Buffer DMA Engine

This block moves bytes between host memory and a private 4096-byte buffer. Software loads three 64-bit registers: a source address, a destination address and a byte count. It then writes a command word whose low bits start the copy, choose its direction and ask for a completion interrupt. The buffer is reached through a fixed device-side window at 0x40000, so the device-side address minus 0x40000 gives the buffer index. Host addresses must stay below a configurable mask limit, 28 bits by default.

Data moves one byte per beat over a request/acknowledge host-memory port. The start bit stays readable as 1 while the engine works, so software polls it to learn when the copy has finished. A request whose buffer range or host range falls outside its limits is refused without any host traffic, and a readable error flag is set. A completed copy with the interrupt enabled produces a one-cycle pulse carrying the code 0x100.

Top module: `hbd_dma_engine`

## Requirements
- R1: After reset, the four registers read zero, no host request is raised and no interrupt pulse is given.
- R2: The registers sit at offset 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command). An 8-byte access reaches all 64 bits. A 4-byte access at the base offset reaches bits 31:0, and one at base+4 reaches bits 63:32, which read back in bits 31:0.
- R3: Command bit 0 written as 1 starts a transfer. It reads 1 from the cycle after that write until completion. Bit 1 (direction) and bit 2 (interrupt enable) read back as written. A write with bit 0 clear starts nothing.
- R4: With direction 0, byte i is read from host address source+i and stored at buffer index destination-0x40000+i.
- R5: With direction 1, buffer index source-0x40000+i is written to host address destination+i, in ascending order of i.
- R6: While a host request waits for its acknowledge, the request, the address, the write flag and the write data hold steady. Each acknowledge moves exactly one byte.
- R7: If the device-side address is below 0x40000, or address+count exceeds 0x40000+4096, the transfer is refused. No host request is made, bit 0 clears, command bit 3 (error) reads 1, and no interrupt is given.
- R8: If host address+count exceeds 2^28 (the default mask), the transfer is refused in the same way as R7.
- R9: Writes to any of the four registers while a transfer is busy are ignored, and the running transfer uses the values latched at start.
- R10: A count of zero completes at once with no host request. Bit 0 clears, and the interrupt is given if enabled.
- R11: When a transfer completes successfully with bit 2 set, a one-cycle interrupt pulse appears with code 0x100. Nothing appears when bit 2 is clear.
- R12: The error flag clears when the next transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational from reg_addr) |
| hm_req | output | 1 | Host-memory beat request |
| hm_we | output | 1 | 1 = host write, 0 = host read |
| hm_addr | output | MASK_BITS | Host byte address |
| hm_wdata | output | 8 | Byte written to host |
| hm_ack | input | 1 | Host acknowledge; a beat completes when request and acknowledge are both high |
| hm_rdata | input | 8 | Byte read from host, valid with acknowledge |
| irq_pulse | output | 1 | One-cycle completion interrupt |
| irq_code | output | 32 | 0x100 during the pulse, otherwise 0 |

## Verification
A beat counter that goes wrong shows at once in the next host address, or at the end as a wrong count of acknowledged beats. A wrong buffer index stays hidden until the same region is copied back out, so every load into the buffer is followed by a readback that compares each byte and its host address. A stuck sequencer shows as a start bit that never clears while being polled. A wrong range decision shows within two cycles as host traffic that should not exist, or as a wrong error bit.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  localparam int REG_W = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HRD,
    ST_FETCH,
    ST_HWR
  } hbd_state_e;

  localparam logic [7:0] OFS_SRC = 8'h80;
  localparam logic [7:0] OFS_DST = 8'h88;
  localparam logic [7:0] OFS_CNT = 8'h90;
  localparam logic [7:0] OFS_CMD = 8'h98;

  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IEN = 2;
  localparam int CMD_ERR = 3;

  localparam logic [31:0] IRQ_DONE_CODE = 32'h0000_0100;

  // device range [dev, dev+cnt) must lie inside [base, base+size)
  function automatic logic win_fits(input logic [REG_W-1:0] dev, input logic [REG_W-1:0] cnt,
                                    input logic [REG_W-1:0] base, input logic [REG_W-1:0] size);
    logic [REG_W:0] last_x;
    logic [REG_W:0] lim_x;
    last_x = {1'b0, dev} + {1'b0, cnt};
    lim_x  = {1'b0, base} + {1'b0, size};
    return (dev >= base) && (last_x <= lim_x);
  endfunction

  // host range [host, host+cnt) must lie below 2**bits
  function automatic logic host_fits(input logic [REG_W-1:0] host, input logic [REG_W-1:0] cnt,
                                     input int unsigned bits);
    logic [REG_W:0] last_x;
    logic [REG_W:0] lim_x;
    last_x = {1'b0, host} + {1'b0, cnt};
    lim_x  = (REG_W+1)'(1) << bits;
    return last_x <= lim_x;
  endfunction

  function automatic logic [REG_W-1:0] merge_write(input logic [REG_W-1:0] old, input logic [REG_W-1:0] wd,
                                                   input logic wide, input logic hi);
    if (wide) return wd;
    if (hi)   return {wd[31:0], old[31:0]};
    return {old[63:32], wd[31:0]};
  endfunction

  function automatic logic [REG_W-1:0] read_view(input logic [REG_W-1:0] v, input logic wide, input logic hi);
    if (wide) return hi ? '0 : v;
    return hi ? {32'b0, v[63:32]} : {32'b0, v[31:0]};
  endfunction

endpackage

// File: rtl/hbd_bufram.sv
module hbd_bufram #(
  parameter int DEPTH = 4096,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/hbd_regs.sv
module hbd_regs
  import hbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic             wide,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             busy,
  input  logic             done_err,
  output logic [REG_W-1:0] src_o,
  output logic [REG_W-1:0] dst_o,
  output logic [REG_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             ien_o,
  output logic             start_o
);

  logic [REG_W-1:0] src_q, dst_q, cnt_q;
  logic dir_q, ien_q, err_q;

  logic hi, acc_ok;
  logic wr_src, wr_dst, wr_cnt, wr_cmd;
  logic [REG_W-1:0] cmd_view;

  assign hi     = addr[2];
  assign acc_ok = (addr[1:0] == 2'b00) && !(wide && hi) && !busy;

  assign wr_src = wr_en && acc_ok && (addr[7:3] == OFS_SRC[7:3]);
  assign wr_dst = wr_en && acc_ok && (addr[7:3] == OFS_DST[7:3]);
  assign wr_cnt = wr_en && acc_ok && (addr[7:3] == OFS_CNT[7:3]);
  assign wr_cmd = wr_en && acc_ok && !hi && (addr[7:3] == OFS_CMD[7:3]);

  assign start_o = wr_cmd && wdata[CMD_GO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
      ien_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (wr_src) src_q <= merge_write(src_q, wdata, wide, hi);
      if (wr_dst) dst_q <= merge_write(dst_q, wdata, wide, hi);
      if (wr_cnt) cnt_q <= merge_write(cnt_q, wdata, wide, hi);
      if (wr_cmd) begin
        dir_q <= wdata[CMD_DIR];
        ien_q <= wdata[CMD_IEN];
      end
      if (start_o)       err_q <= 1'b0;
      else if (done_err) err_q <= 1'b1;
    end
  end

  always_comb begin
    cmd_view = '0;
    cmd_view[CMD_GO]  = busy;
    cmd_view[CMD_DIR] = dir_q;
    cmd_view[CMD_IEN] = ien_q;
    cmd_view[CMD_ERR] = err_q;
  end

  always_comb begin
    unique case (addr[7:3])
      OFS_SRC[7:3]: rdata = read_view(src_q, wide, hi);
      OFS_DST[7:3]: rdata = read_view(dst_q, wide, hi);
      OFS_CNT[7:3]: rdata = read_view(cnt_q, wide, hi);
      OFS_CMD[7:3]: rdata = read_view(cmd_view, wide, hi);
      default:      rdata = '0;
    endcase
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = cnt_q;
  assign dir_o = dir_q;
  assign ien_o = ien_q;

  // R9: programming state is frozen across a busy cycle
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q) && $stable(dir_q) && $stable(ien_q)));

  // R7: error flag only rises at the end of a busy period
  assert_err_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(busy) && !busy));

endmodule

// File: rtl/hbd_seq.sv
module hbd_seq
  import hbd_pkg::*;
#(
  parameter int unsigned      MASK_BITS = 28,
  parameter int unsigned      BUF_BYTES = 4096,
  parameter logic [REG_W-1:0] WIN_BASE  = 64'h40000,
  parameter int unsigned      BUF_AW    = $clog2(BUF_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [REG_W-1:0]     src,
  input  logic [REG_W-1:0]     dst,
  input  logic [REG_W-1:0]     cnt,
  input  logic                 dir,
  output logic                 busy,
  output logic                 done_ok,
  output logic                 done_err,
  output logic                 hm_req,
  output logic                 hm_we,
  output logic [MASK_BITS-1:0] hm_addr,
  output logic [7:0]           hm_wdata,
  input  logic                 hm_ack,
  input  logic [7:0]           hm_rdata,
  output logic                 buf_we,
  output logic [BUF_AW-1:0]    buf_waddr,
  output logic [7:0]           buf_wdata,
  output logic                 buf_re,
  output logic [BUF_AW-1:0]    buf_raddr,
  input  logic [7:0]           buf_rdata
);

  localparam int unsigned IDX_W = BUF_AW + 1;

  hbd_state_e state;
  logic [IDX_W-1:0] idx;

  logic [REG_W-1:0] host_base, dev_base;
  logic [BUF_AW-1:0] buf_base, buf_idx;
  logic range_ok, zero_cnt, last_beat, beat_done;

  assign host_base = dir ? dst : src;
  assign dev_base  = dir ? src : dst;
  assign buf_base  = BUF_AW'(dev_base - WIN_BASE);
  assign buf_idx   = buf_base + idx[BUF_AW-1:0];

  assign range_ok  = win_fits(dev_base, cnt, WIN_BASE, REG_W'(BUF_BYTES)) &&
                     host_fits(host_base, cnt, MASK_BITS);
  assign zero_cnt  = (cnt == '0);
  assign last_beat = ((idx + IDX_W'(1)) == cnt[IDX_W-1:0]);

  assign busy      = (state != ST_IDLE);
  assign hm_req    = (state == ST_HRD) || (state == ST_HWR);
  assign hm_we     = (state == ST_HWR);
  assign hm_addr   = MASK_BITS'(host_base + REG_W'(idx));
  assign hm_wdata  = buf_rdata;
  assign beat_done = hm_req && hm_ack;

  assign buf_we    = (state == ST_HRD) && hm_ack;
  assign buf_waddr = buf_idx;
  assign buf_wdata = hm_rdata;
  assign buf_re    = (state == ST_FETCH);
  assign buf_raddr = buf_idx;

  assign done_err  = (state == ST_CHECK) && !zero_cnt && !range_ok;
  assign done_ok   = ((state == ST_CHECK) && zero_cnt) || (beat_done && last_beat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (start) state <= ST_CHECK;
        ST_CHECK: begin
          if (zero_cnt || !range_ok) begin
            state <= ST_IDLE;
          end else begin
            idx   <= '0;
            state <= dir ? ST_FETCH : ST_HRD;
          end
        end
        ST_HRD: begin
          if (hm_ack) begin
            if (last_beat) state <= ST_IDLE;
            else           idx   <= idx + IDX_W'(1);
          end
        end
        ST_FETCH: state <= ST_HWR;
        ST_HWR: begin
          if (hm_ack) begin
            if (last_beat) begin
              state <= ST_IDLE;
            end else begin
              idx   <= idx + IDX_W'(1);
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a waiting beat keeps its request, address, kind and data
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hm_req && !hm_ack) |=> (hm_req && $stable(hm_addr) && $stable(hm_we) && $stable(hm_wdata)));

  // R3: any completion or refusal leaves the engine idle on the next cycle
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_err) |=> !busy);

  // R7: a refusal never coincides with a completion
  assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_err));

endmodule

// File: rtl/hbd_dma_engine.sv
module hbd_dma_engine
  import hbd_pkg::*;
#(
  parameter int unsigned      MASK_BITS = 28,
  parameter int unsigned      BUF_BYTES = 4096,
  parameter logic [REG_W-1:0] WIN_BASE  = 64'h40000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_addr,
  input  logic                 reg_wide,
  input  logic [63:0]          reg_wdata,
  output logic [63:0]          reg_rdata,
  output logic                 hm_req,
  output logic                 hm_we,
  output logic [MASK_BITS-1:0] hm_addr,
  output logic [7:0]           hm_wdata,
  input  logic                 hm_ack,
  input  logic [7:0]           hm_rdata,
  output logic                 irq_pulse,
  output logic [31:0]          irq_code
);

  localparam int unsigned BUF_AW = $clog2(BUF_BYTES);

  logic [REG_W-1:0] src, dst, cnt;
  logic dir, ien, start, busy, done_ok, done_err;
  logic buf_we, buf_re;
  logic [BUF_AW-1:0] buf_waddr, buf_raddr;
  logic [7:0] buf_wdata, buf_rdata;
  logic irq_q;

  hbd_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wide     (reg_wide),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .busy     (busy),
    .done_err (done_err),
    .src_o    (src),
    .dst_o    (dst),
    .cnt_o    (cnt),
    .dir_o    (dir),
    .ien_o    (ien),
    .start_o  (start)
  );

  hbd_seq #(
    .MASK_BITS (MASK_BITS),
    .BUF_BYTES (BUF_BYTES),
    .WIN_BASE  (WIN_BASE),
    .BUF_AW    (BUF_AW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src       (src),
    .dst       (dst),
    .cnt       (cnt),
    .dir       (dir),
    .busy      (busy),
    .done_ok   (done_ok),
    .done_err  (done_err),
    .hm_req    (hm_req),
    .hm_we     (hm_we),
    .hm_addr   (hm_addr),
    .hm_wdata  (hm_wdata),
    .hm_ack    (hm_ack),
    .hm_rdata  (hm_rdata),
    .buf_we    (buf_we),
    .buf_waddr (buf_waddr),
    .buf_wdata (buf_wdata),
    .buf_re    (buf_re),
    .buf_raddr (buf_raddr),
    .buf_rdata (buf_rdata)
  );

  hbd_bufram #(
    .DEPTH (BUF_BYTES),
    .AW    (BUF_AW)
  ) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .re    (buf_re),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= done_ok && ien;
  end

  assign irq_pulse = irq_q;
  assign irq_code  = irq_q ? IRQ_DONE_CODE : 32'h0;

  // R11: the completion interrupt lasts a single cycle
  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R11: the interrupt is only given once the engine is idle again
  assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !busy);

endmodule

// File: tb/hbd_dma_engine_tb.sv
`timescale 1ns/100ps
module hbd_dma_engine_tb;

  localparam int MB = 28;
  localparam int BUFN = 4096;
  localparam logic [63:0] WIN = 64'h40000;
  localparam logic [63:0] HTOP = 64'h1 << MB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h0;
  logic reg_wide = 1'b0;
  logic [63:0] reg_wdata = 64'h0;
  logic [63:0] reg_rdata;
  logic hm_req, hm_we;
  logic [MB-1:0] hm_addr;
  logic [7:0] hm_wdata;
  logic hm_ack = 1'b0;
  logic [7:0] hm_rdata = 8'h0;
  logic irq_pulse;
  logic [31:0] irq_code;

  always #2 clk = ~clk;

  hbd_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wide(reg_wide),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hm_req(hm_req), .hm_we(hm_we), .hm_addr(hm_addr), .hm_wdata(hm_wdata),
    .hm_ack(hm_ack), .hm_rdata(hm_rdata),
    .irq_pulse(irq_pulse), .irq_code(irq_code)
  );

  int total = 0;
  int bad = 0;
  int rd_beats = 0, wr_beats = 0, irq_seen = 0, req_cycles = 0;
  logic [63:0] wlog_addr [BUFN];
  logic [7:0]  wlog_data [BUFN];
  logic [7:0]  shadow    [BUFN];
  bit prev_wait = 0;
  logic [MB-1:0] prev_addr;
  logic prev_we;
  logic [7:0] prev_wdata;
  bit ack_now;

  function automatic logic [7:0] hfun(input logic [63:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA7;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // host memory model and event monitor, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_wait)
        chk(hm_req && hm_addr == prev_addr && hm_we == prev_we && (!prev_we || hm_wdata == prev_wdata),
            "R6", 64'(hm_addr), 64'(prev_addr), "request held while waiting");
      ack_now  = hm_req && ($urandom_range(0, 2) != 0);
      hm_ack   = ack_now;
      hm_rdata = hfun(64'(hm_addr));
      if (hm_req) req_cycles++;
      if (ack_now && hm_we) begin
        if (wr_beats < BUFN) begin
          wlog_addr[wr_beats] = 64'(hm_addr);
          wlog_data[wr_beats] = hm_wdata;
        end
        wr_beats++;
      end
      if (ack_now && !hm_we) rd_beats++;
      if (irq_pulse) begin
        irq_seen++;
        chk(irq_code == 32'h100, "R11", 64'(irq_code), 64'h100, "interrupt code");
      end
      prev_wait  = hm_req && !ack_now;
      prev_addr  = hm_addr;
      prev_we    = hm_we;
      prev_wdata = hm_wdata;
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [63:0] d, input bit wide);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = wide;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input bit wide, output logic [63:0] v);
    @(negedge clk);
    reg_addr = a; reg_wide = wide;
    #1;
    v = reg_rdata;
  endtask

  task automatic zero_ctrs();
    @(negedge clk); #1;
    rd_beats = 0; wr_beats = 0; irq_seen = 0; req_cycles = 0;
  endtask

  task automatic start_xfer(input logic [63:0] s, input logic [63:0] d, input logic [63:0] n,
                            input logic [63:0] cmd);
    wr_reg(8'h80, s, 1);
    wr_reg(8'h88, d, 1);
    wr_reg(8'h90, n, 1);
    zero_ctrs();
    wr_reg(8'h98, cmd, 0);
  endtask

  task automatic wait_done(output logic [63:0] fin);
    logic [63:0] v;
    do rd_reg(8'h98, 0, v); while (v[0]);
    fin = v;
  endtask

  task automatic run_xfer(input logic [63:0] s, input logic [63:0] d, input logic [63:0] n,
                          input logic [63:0] cmd, output logic [63:0] fin, output bit saw_busy);
    logic [63:0] v;
    start_xfer(s, d, n, cmd);
    rd_reg(8'h98, 0, v);
    saw_busy = v[0];
    wait_done(fin);
  endtask

  task automatic load_buf(input logic [63:0] hs, input int off, input int n, input bit ie);
    logic [63:0] fin;
    bit sb;
    run_xfer(hs, WIN + 64'(off), 64'(n), ie ? 64'h5 : 64'h1, fin, sb);
    chk(sb, "R3", 64'(sb), 1, "start bit reads busy");
    chk(rd_beats == n && fin[3] == 1'b0, "R4", 64'(rd_beats), 64'(n), "host read beats");
    chk(irq_seen == (ie ? 1 : 0), "R11", 64'(irq_seen), ie ? 64'h1 : 64'h0, "interrupt count on load");
    for (int i = 0; i < n; i++) shadow[off + i] = hfun(hs + 64'(i));
  endtask

  task automatic check_back(input int off, input int n, input logic [63:0] hd, input string req);
    logic [63:0] fin;
    bit sb;
    int mism;
    run_xfer(WIN + 64'(off), hd, 64'(n), 64'h3, fin, sb);
    mism = 0;
    for (int i = 0; i < n && i < BUFN; i++)
      if (wlog_addr[i] != ((hd + 64'(i)) & (HTOP - 1)) || wlog_data[i] != shadow[off + i]) mism++;
    chk(wr_beats == n && mism == 0 && fin[3] == 1'b0, req, 64'(mism), 0, "readback mismatches");
    chk(irq_seen == 0, "R11", 64'(irq_seen), 0, "no interrupt when disabled");
  endtask

  task automatic expect_reject(input logic [63:0] s, input logic [63:0] d, input logic [63:0] n,
                               input logic [63:0] cmd, input string req);
    logic [63:0] fin;
    bit sb;
    run_xfer(s, d, n, cmd, fin, sb);
    chk(fin[3] == 1'b1 && fin[0] == 1'b0, req, fin, 64'h8, "refused transfer flags");
    chk(req_cycles == 0 && irq_seen == 0, req, 64'(req_cycles + irq_seen), 0, "refused transfer traffic");
  endtask

  initial begin
    logic [63:0] v, fin;
    bit sb;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(hm_req == 1'b0 && irq_pulse == 1'b0, "R1", {62'b0, hm_req, irq_pulse}, 0, "idle outputs");
    for (int k = 0; k < 4; k++) begin
      rd_reg(8'h80 + 8'(k * 8), 1, v);
      chk(v == 0, "R1", v, 0, "register reset value");
    end

    // R2 access widths
    wr_reg(8'h80, 64'h0123_4567_89AB_CDEF, 1);
    rd_reg(8'h80, 1, v);
    chk(v == 64'h0123_4567_89AB_CDEF, "R2", v, 64'h0123_4567_89AB_CDEF, "8-byte readback");
    rd_reg(8'h84, 0, v);
    chk(v == 64'h0123_4567, "R2", v, 64'h0123_4567, "upper half read");
    wr_reg(8'h84, 64'hDEAD_BEEF, 0);
    rd_reg(8'h80, 1, v);
    chk(v == 64'hDEAD_BEEF_89AB_CDEF, "R2", v, 64'hDEAD_BEEF_89AB_CDEF, "upper half write");
    wr_reg(8'h90, 64'h1111_2222_3333_4444, 1);
    wr_reg(8'h90, 64'h5555_6666, 0);
    rd_reg(8'h90, 1, v);
    chk(v == 64'h1111_2222_5555_6666, "R2", v, 64'h1111_2222_5555_6666, "lower half write");

    // R3 command without start
    zero_ctrs();
    wr_reg(8'h98, 64'h6, 0);
    repeat (3) @(negedge clk);
    rd_reg(8'h98, 0, v);
    chk(v == 64'h6 && req_cycles == 0, "R3", v, 64'h6, "dir and enable read back, no start");

    // R4 full buffer load, interrupt enabled
    load_buf(64'h0012_3000, 0, BUFN, 1);
    check_back(0, 64, 64'h0500_0000, "R5");
    check_back(4000, 96, 64'h0600_0010, "R4");

    // random mix of loads and readbacks
    for (int it = 0; it < 24; it++) begin
      int off, n, o2, n2;
      logic [63:0] hs;
      bit ie;
      off = $urandom_range(0, BUFN - 64);
      n   = $urandom_range(1, 64);
      hs  = 64'($urandom_range(0, 32'h0FFF_FF00));
      ie  = bit'($urandom_range(0, 1));
      load_buf(hs, off, n, ie);
      o2 = $urandom_range(0, BUFN - 128);
      n2 = $urandom_range(1, 128);
      check_back(o2, n2, 64'($urandom_range(0, 32'h0FFF_FF00)), "R5");
    end

    // R7 window edges
    load_buf(64'h1000, BUFN - 16, 16, 0);
    check_back(BUFN - 16, 16, 64'h2000, "R7");
    expect_reject(64'h1000, WIN + 64'(BUFN - 15), 64'd16, 64'h5, "R7");
    expect_reject(64'h1000, WIN - 1, 64'd4, 64'h1, "R7");
    expect_reject(WIN + 64'(BUFN - 6), 64'h3000, 64'd8, 64'h7, "R7");

    // R8 host mask edges
    check_back(100, 8, HTOP - 8, "R8");
    expect_reject(WIN, HTOP - 7, 64'd8, 64'h3, "R8");
    expect_reject(HTOP - 4, WIN, 64'd8, 64'h5, "R8");

    // R10 zero count, R12 error cleared by accepted start
    run_xfer(64'h0, 64'h0, 64'h0, 64'h5, fin, sb);
    chk(sb, "R3", 64'(sb), 1, "start bit reads busy on zero count");
    chk(fin[3] == 1'b0, "R12", fin, 64'h4, "error cleared");
    chk(req_cycles == 0 && fin[0] == 1'b0, "R10", 64'(req_cycles), 0, "zero count no traffic");
    chk(irq_seen == 1, "R10", 64'(irq_seen), 1, "zero count interrupt");
    run_xfer(64'h0, 64'h0, 64'h0, 64'h1, fin, sb);
    chk(irq_seen == 0, "R11", 64'(irq_seen), 0, "zero count, interrupt disabled");

    // R9 writes ignored while busy
    start_xfer(64'h0055_0000, WIN + 64'h200, 64'd256, 64'h1);
    wr_reg(8'h80, 64'h777, 1);
    wr_reg(8'h88, 64'h888, 1);
    wr_reg(8'h90, 64'h5, 1);
    wr_reg(8'h98, 64'h7, 0);
    rd_reg(8'h80, 1, v);
    chk(v == 64'h0055_0000, "R9", v, 64'h0055_0000, "source kept");
    rd_reg(8'h88, 1, v);
    chk(v == WIN + 64'h200, "R9", v, WIN + 64'h200, "destination kept");
    rd_reg(8'h90, 1, v);
    chk(v == 64'd256, "R9", v, 64'd256, "count kept");
    rd_reg(8'h98, 0, v);
    chk(v[2:0] == 3'b001, "R9", v, 64'h1, "command kept, still busy");
    wait_done(fin);
    chk(rd_beats == 256 && irq_seen == 0, "R9", 64'(rd_beats), 256, "original count used");
    for (int i = 0; i < 256; i++) shadow[512 + i] = hfun(64'h0055_0000 + 64'(i));
    check_back(512, 256, 64'h0077_0000, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule